// File: doc/BRIEF.md
# Circular-Buffer DMA Write Channel

This block generates addresses for one DMA channel that moves data from an I/O device into a fixed circular area of memory. Software programs a base address and an element count for the area, and sets a transfer width of 8, 16 or 32 bits. Each element the device offers is turned into one memory write request at the current address. The address then steps forward by the element size. When the programmed number of elements has been written, the channel reloads the base address and the count by itself and keeps writing from the base of the area. This overwrites data that software has already consumed.

A stop address tells the channel how far it may go. Software keeps it at the first location it has not read yet. In circular mode the channel withholds its acknowledge from the device while its next write address equals the stop address. It resumes as soon as software moves the stop address on. When circular mode is off, the channel makes a single linear pass, raises a terminal-count flag and halts. The current write address is always visible, so software can work out how much unread data the area holds.

Top module: `ring_dma_writer`

## Requirements
- R1: During and after reset, io_ready, mem_wr and tc are low and cur_addr is zero. The base address, count and control registers reset to zero, and the stop register resets to one.
- R2: A configuration write with cfg_sel=3 loads control: bit 0 run, bit 1 circular, bits 3:2 size. When run is set, the write sets cur_addr to the base address (cfg_sel=0), clears tc and arms the channel. io_ready is low in any cycle that carries a control write.
- R3: Each cycle with io_valid and io_ready high produces mem_wr in the same cycle, with mem_addr=cur_addr, mem_wdata=io_data and mem_size=size. cur_addr then advances by 1, 2 or 4 bytes for size 0, 1 or 2. Size 3 also advances by 4.
- R4: The count register (cfg_sel=1) holds the number of elements minus one. In circular mode, the write that uses up the count returns cur_addr to the base address and reloads the count.
- R5: In circular mode, io_ready is low while cur_addr equals the stop register (cfg_sel=2), including right after a wrap. Writing a different stop value lets transfers resume.
- R6: If the stop register is left at its reset value and the base is zero with 8-bit size, exactly one element is written before the channel stalls.
- R7: In linear mode (circular bit clear), the write that uses up the count advances cur_addr, sets tc and drops io_ready. Later io_valid cycles produce no mem_wr.
- R8: In linear mode, the stop register has no effect on io_ready.
- R9: A base or count write while the channel runs does not change the pass in progress. The new values take effect at the next wrap.
- R10: A control write with run clear drops io_ready from the next cycle. It leaves cur_addr and tc unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 2 | Register select: 0 base, 1 count-1, 2 stop, 3 control |
| cfg_wdata | input | ADDR_W | Configuration write data |
| io_valid | input | 1 | Device has an element ready |
| io_data | input | DATA_W | Element from the device |
| io_ready | output | 1 | Channel accepts the element this cycle |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Byte address of the write |
| mem_wdata | output | DATA_W | Data of the write |
| mem_size | output | 2 | Size code of the write |
| tc | output | 1 | Terminal count reached in linear mode |
| cur_addr | output | ADDR_W | Current write address (status) |

## Verification
The bench builds the block with ADDR_W=16, CNT_W=4 and DATA_W=32. The 4-bit count keeps circular areas at up to sixteen elements, so many wraps, reloads during a pass and stalls right after a wrap all fit into a short run. A behavioural model predicts io_ready, mem_wr, the write fields, tc and cur_addr every cycle. Scenario checks cover three situations with hand-computed addresses: a stall at the reset stop value, an area with the stop equal to the base, and a linear pass that runs over a stop value it must ignore.

// File: rtl/ringwr_pkg.sv
`timescale 1ns/1ps
package ringwr_pkg;

  typedef enum logic [1:0] {
    SEL_BASE  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_STOP  = 2'd2,
    SEL_CTRL  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_WORD2 = 2'd3
  } xfer_size_e;

  // packed: size in [3:2], circular in [1], run in [0]
  typedef struct packed {
    xfer_size_e size;
    logic       circ;
    logic       run;
  } chan_ctrl_t;

  function automatic logic [2:0] size_step(input xfer_size_e s);
    case (s)
      SZ_BYTE: size_step = 3'd1;
      SZ_HALF: size_step = 3'd2;
      default: size_step = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/ringwr_regs.sv
`timescale 1ns/1ps
module ringwr_regs
  import ringwr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] base_q,
  output logic [CNT_W-1:0]  count_q,
  output logic [ADDR_W-1:0] stop_q,
  output chan_ctrl_t        ctrl_q,
  output logic              ctrl_wr,
  output chan_ctrl_t        ctrl_new
);

  localparam logic [ADDR_W-1:0] STOP_RST = ADDR_W'(1);

  logic [ADDR_W-1:0] base_d, stop_d;
  logic [CNT_W-1:0]  count_d;
  chan_ctrl_t        ctrl_d;

  assign ctrl_wr  = cfg_we && (reg_sel_e'(cfg_sel) == SEL_CTRL);
  assign ctrl_new = chan_ctrl_t'(cfg_wdata[3:0]);

  always_comb begin
    base_d  = base_q;
    count_d = count_q;
    stop_d  = stop_q;
    ctrl_d  = ctrl_q;
    if (cfg_we) begin
      case (reg_sel_e'(cfg_sel))
        SEL_BASE:  base_d  = cfg_wdata;
        SEL_COUNT: count_d = cfg_wdata[CNT_W-1:0];
        SEL_STOP:  stop_d  = cfg_wdata;
        default:   ctrl_d  = ctrl_new;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      count_q <= '0;
      stop_q  <= STOP_RST;
      ctrl_q  <= '0;
    end else if (cfg_we) begin
      base_q  <= base_d;
      count_q <= count_d;
      stop_q  <= stop_d;
      ctrl_q  <= ctrl_d;
    end
  end

endmodule

// File: rtl/ringwr_flow.sv
`timescale 1ns/1ps
module ringwr_flow #(
  parameter int ADDR_W = 32
) (
  input  logic              active,
  input  logic              circ,
  input  logic              ctrl_wr,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [ADDR_W-1:0] stop_addr,
  input  logic              io_valid,
  output logic              io_ready,
  output logic              xfer
);

  logic at_stop;

  always_comb begin
    at_stop  = circ && (cur_addr == stop_addr);
    io_ready = active && !ctrl_wr && !at_stop;
    xfer     = io_ready && io_valid;
  end

endmodule

// File: rtl/ringwr_addr_gen.sv
`timescale 1ns/1ps
module ringwr_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              halt,
  input  logic              xfer,
  input  logic              circ,
  input  logic [ADDR_W-1:0] step,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  count,
  output logic [ADDR_W-1:0] cur_q,
  output logic              active_q,
  output logic              tc_q
);

  logic [ADDR_W-1:0] cur_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic              active_d, tc_d, last;

  assign last = (rem_q == '0);

  always_comb begin
    cur_d    = cur_q;
    rem_d    = rem_q;
    active_d = active_q;
    tc_d     = tc_q;
    if (load) begin
      cur_d    = base;
      rem_d    = count;
      active_d = 1'b1;
      tc_d     = 1'b0;
    end else if (halt) begin
      active_d = 1'b0;
    end else if (xfer) begin
      if (!last) begin
        cur_d = cur_q + step;
        rem_d = rem_q - 1'b1;
      end else if (circ) begin
        cur_d = base;
        rem_d = count;
      end else begin
        cur_d    = cur_q + step;
        active_d = 1'b0;
        tc_d     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q    <= '0;
      rem_q    <= '0;
      active_q <= 1'b0;
      tc_q     <= 1'b0;
    end else begin
      cur_q    <= cur_d;
      rem_q    <= rem_d;
      active_q <= active_d;
      tc_q     <= tc_d;
    end
  end

  // R7: terminal count always means the channel has stopped
  a_r7_tc_halts: assert property (@(posedge clk) disable iff (!rst_n)
    tc_q |-> !active_q);

  // R4: the element that uses up the count brings the address back to the base
  a_r4_wrap_to_base: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && last && circ) |=> (cur_q == $past(base)));

  // R3: a transfer inside a pass moves the address by one element
  a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !last) |=> (cur_q == $past(cur_q) + $past(step)));

endmodule

// File: rtl/ring_dma_writer.sv
`timescale 1ns/1ps
module ring_dma_writer
  import ringwr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              io_valid,
  input  logic [DATA_W-1:0] io_data,
  output logic              io_ready,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [1:0]        mem_size,
  output logic              tc,
  output logic [ADDR_W-1:0] cur_addr
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [ADDR_W-1:0] base_q, stop_q, step;
  logic [CNT_W-1:0]  count_q;
  chan_ctrl_t        ctrl_q, ctrl_new;
  logic              ctrl_wr, active, xfer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ringwr_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .base_q(base_q), .count_q(count_q),
    .stop_q(stop_q), .ctrl_q(ctrl_q), .ctrl_wr(ctrl_wr), .ctrl_new(ctrl_new)
  );

  assign step = ADDR_W'(size_step(ctrl_q.size));

  ringwr_flow #(.ADDR_W(ADDR_W)) u_flow (
    .active(active), .circ(ctrl_q.circ), .ctrl_wr(ctrl_wr),
    .cur_addr(cur_addr), .stop_addr(stop_q), .io_valid(io_valid),
    .io_ready(io_ready), .xfer(xfer)
  );

  ringwr_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_agen (
    .clk(clk), .rst_n(rst_int_n),
    .load(ctrl_wr && ctrl_new.run), .halt(ctrl_wr && !ctrl_new.run),
    .xfer(xfer), .circ(ctrl_q.circ), .step(step), .base(base_q),
    .count(count_q), .cur_q(cur_addr), .active_q(active), .tc_q(tc)
  );

  assign mem_wr    = xfer;
  assign mem_addr  = cur_addr;
  assign mem_wdata = io_data;
  assign mem_size  = ctrl_q.size;

  // R5: in circular mode no write ever lands on the stop address
  a_r5_no_write_at_stop: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mem_wr && ctrl_q.circ) |-> (mem_addr != stop_q));

  // R10: clearing run closes the handshake from the next cycle
  a_r10_halt_closes: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ctrl_wr && !ctrl_new.run) |=> !io_ready);

  // R7: after terminal count the device is never acknowledged
  a_r7_no_ack_after_tc: assert property (@(posedge clk) disable iff (!rst_int_n)
    tc |-> !io_ready);

  // R2: a control write cycle never acknowledges the device
  a_r2_ctrl_blocks: assert property (@(posedge clk) disable iff (!rst_int_n)
    ctrl_wr |-> !mem_wr);

endmodule

// File: tb/test_ring_dma_writer.sv
`timescale 1ns/1ps
module test_ring_dma_writer;

  localparam int AW = 16;
  localparam int CW = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [1:0]    cfg_sel;
  logic [AW-1:0] cfg_wdata;
  logic          io_valid;
  logic [DW-1:0] io_data;
  logic          io_ready, mem_wr, tc;
  logic [AW-1:0] mem_addr, cur_addr;
  logic [DW-1:0] mem_wdata;
  logic [1:0]    mem_size;

  int checks = 0;
  int failures = 0;

  // behavioural reference state
  logic [AW-1:0] m_base, m_stop, m_cur;
  int            m_cnt, m_rem;
  bit            m_act, m_tc, m_circ;
  int            m_size;
  logic [DW-1:0] next_data;

  always #5 clk = ~clk;

  ring_dma_writer #(.ADDR_W(AW), .CNT_W(CW), .DATA_W(DW)) i_ring_dma_writer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .io_valid(io_valid), .io_data(io_data),
    .io_ready(io_ready), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_size(mem_size), .tc(tc), .cur_addr(cur_addr)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int step_of(input int s);
    return (s == 0) ? 1 : (s == 1) ? 2 : 4;
  endfunction

  // one clock: drive at falling edge, compare, then advance the model at the rising edge
  task automatic cyc(input bit we, input int sel, input int wd, input bit vld);
    bit exp_rdy, exp_wr;
    @(negedge clk);
    cfg_we = we; cfg_sel = sel[1:0]; cfg_wdata = wd[AW-1:0];
    io_valid = vld; io_data = next_data;
    #1;
    exp_rdy = m_act && !(we && sel == 3) && !(m_circ && m_cur == m_stop);
    exp_wr  = exp_rdy && vld;
    chk(io_ready == exp_rdy, "R5 io_ready", io_ready, exp_rdy);
    chk(mem_wr == exp_wr, "R3 mem_wr", mem_wr, exp_wr);
    chk(tc == m_tc, "R7 tc", tc, m_tc);
    chk(cur_addr == m_cur, "R4 cur_addr", cur_addr, m_cur);
    if (exp_wr) begin
      chk(mem_addr == m_cur, "R3 mem_addr", mem_addr, m_cur);
      chk(mem_wdata == next_data, "R3 mem_wdata", mem_wdata, next_data);
      chk(mem_size == m_size[1:0], "R3 mem_size", mem_size, m_size);
    end
    @(posedge clk);
    if (we) begin
      case (sel)
        0: m_base = wd[AW-1:0];
        1: m_cnt  = wd & ((1 << CW) - 1);
        2: m_stop = wd[AW-1:0];
        default: begin
          m_circ = wd[1];
          m_size = (wd >> 2) & 3;
          if (wd[0]) begin
            m_cur = m_base; m_rem = m_cnt; m_act = 1; m_tc = 0;
          end else m_act = 0;
        end
      endcase
    end else if (exp_wr) begin
      next_data = next_data * 32'd1103515245 + 32'd12345;
      if (m_rem > 0) begin
        m_cur = m_cur + AW'(step_of(m_size)); m_rem--;
      end else if (m_circ) begin
        m_cur = m_base; m_rem = m_cnt;
      end else begin
        m_cur = m_cur + AW'(step_of(m_size)); m_act = 0; m_tc = 1;
      end
    end
  endtask

  task automatic cfg(input int sel, input int wd);
    cyc(1'b1, sel, wd, 1'b0);
  endtask

  task automatic push(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 0, 0, 1'b1);
  endtask

  task automatic push_gappy(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 0, 0, (i % 3) != 2);
  endtask

  task automatic peek(input logic [AW-1:0] exp_cur, input bit exp_rdy, input string tag);
    @(negedge clk);
    cfg_we = 0; io_valid = 1;
    #1;
    chk(cur_addr == exp_cur, tag, cur_addr, exp_cur);
    chk(io_ready == exp_rdy, tag, io_ready, exp_rdy);
    io_valid = 0;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; io_valid = 1; io_data = 0;
    next_data = 32'h1234_5678;
    m_base = 0; m_stop = 1; m_cur = 0; m_cnt = 0; m_rem = 0;
    m_act = 0; m_tc = 0; m_circ = 0; m_size = 0;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state seen at the ports
    chk(io_ready == 0, "R1 io_ready", io_ready, 0);
    chk(mem_wr == 0, "R1 mem_wr", mem_wr, 0);
    chk(tc == 0, "R1 tc", tc, 0);
    chk(cur_addr == 0, "R1 cur_addr", cur_addr, 0);
    io_valid = 0;
    rst_n = 1;
    repeat (4) @(posedge clk);

    // R6: reset stop value lets one element in
    cfg(1, 7);
    cfg(3, 3);           // run, circular, 8-bit (R2)
    push(5);
    peek(16'h0001, 1'b0, "R6 one element before stall");

    // R5: advancing stop resumes
    cfg(2, 5);
    push(6);
    peek(16'h0005, 1'b0, "R5 stall at new stop");

    // R4: eighth element wraps to base
    cfg(2, 16'h40);
    push(3);
    peek(16'h0000, 1'b1, "R4 wrap to base");

    // R9: new base/count apply only at the next wrap
    cfg(0, 16'h20);
    cfg(1, 3);
    push_gappy(12);
    peek(16'h0020, 1'b1, "R9 deferred base");

    // R3: 16-bit, 32-bit and size code 3 steps
    cfg(3, 7);
    push(2);
    peek(16'h0024, 1'b1, "R3 16-bit step");
    cfg(3, 11);
    push(2);
    peek(16'h0028, 1'b1, "R3 32-bit step");
    cfg(3, 15);
    push(1);
    peek(16'h0024, 1'b1, "R3 size 3 step");

    // R5: stop equal to base stalls at once and after a wrap
    cfg(2, 16'h20);
    cfg(3, 3);
    push(2);
    peek(16'h0020, 1'b0, "R5 stop at base");
    cfg(2, 16'h30);
    push(3);
    cfg(2, 16'h20);
    push(3);
    peek(16'h0020, 1'b0, "R5 stall after wrap");

    // R10: halt keeps address
    cfg(2, 16'h40);
    push(1);
    cfg(3, 2);
    push(3);
    peek(16'h0021, 1'b0, "R10 halt keeps address");

    // R7 and R8: linear pass over a stop value
    cfg(0, 16'h10);
    cfg(1, 2);
    cfg(2, 16'h11);
    cfg(3, 1);
    push(5);
    peek(16'h0013, 1'b0, "R8 stop ignored, R7 halted");
    chk(tc == 1, "R7 tc set", tc, 1);
    cfg(3, 0);
    push(1);
    chk(tc == 1, "R10 tc kept on halt", tc, 1);
    cfg(3, 1);
    peek(16'h0010, 1'b1, "R2 restart");
    chk(tc == 0, "R2 tc cleared", tc, 0);
    push_gappy(9);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule